// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small bank of binary lock flags that two independent agents, a left port and a right port, use to agree on who may touch a shared resource. The flags carry no data path of their own and control nothing in hardware. Software claims a flag by writing a request and then reads the flag back to learn whether the claim succeeded. The flags are active low: a port reads zero only while it owns the flag.

Each flag keeps one request latch per side. A request made against a flag the other side already owns is remembered. When the owner withdraws, the token moves to the waiting side in the same cycle, so the waiting side never has to retry its write. A read result is registered and frozen for as long as the reading port keeps its select and output enable high. A polling loop therefore has to drop one of them between samples.

All state is clocked by a single clock with an asynchronous active-low reset. Each port also has a memory-enable input. It marks an access aimed at a neighbouring RAM, and while it is high the semaphore select on that port is ignored.

Top module: `sem_flags_dual`

## Requirements
- R1: There are eight flags. The flag is chosen by address bits [2:0], and all higher address bits have no effect on which flag is read or written.
- R2: On a semaphore write only data bit 0 counts: 0 places a request and 1 withdraws it. Data bits 7..1 are ignored.
- R3: After reset every flag is free, no request is stored, and both ports read 8'hFF from every flag.
- R4: A request on a free flag makes the requesting side the owner at the write's clock edge. The owner then reads 8'h00 and the other side reads 8'hFF.
- R5: A request from the non-owner leaves the visible flag unchanged on both sides and is stored as pending.
- R6: When the owner withdraws while the other side has a pending request, ownership passes to the other side at that edge. With no pending request the flag becomes free.
- R7: When both sides request the same free flag in the same cycle, the left side becomes owner and the right request stays pending.
- R8: A read (select and output enable high, write low, memory enable low) is registered. The cycle after the read begins, read data equals the flag value on all eight bits. When no read is held, read data is 8'h00.
- R9: The captured read value stays unchanged while select and output enable remain high, even if the flag changes. A new value is captured only after one of them has been dropped.
- R10: When select and memory enable are both high on a port, that port neither writes nor starts a read capture.
- R11: A non-owner that withdraws its pending request no longer receives the token when the owner releases. The flag then becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left semaphore select |
| l_ce | input | 1 | Left memory enable; blocks semaphore access when high |
| l_oe | input | 1 | Left output enable |
| l_we | input | 1 | Left write strobe |
| l_addr | input | ADDR_W (15) | Left address; bits [2:0] select the flag |
| l_wdata | input | DATA_W (8) | Left write data; bit 0 used |
| l_rdata | output | DATA_W (8) | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_ce | input | 1 | Right memory enable; blocks semaphore access when high |
| r_oe | input | 1 | Right output enable |
| r_we | input | 1 | Right write strobe |
| r_addr | input | ADDR_W (15) | Right address; bits [2:0] select the flag |
| r_wdata | input | DATA_W (8) | Right write data; bit 0 used |
| r_rdata | output | DATA_W (8) | Right registered read data |

## Verification
The assertions assume that every input is synchronous to the clock and free of X after reset. They also assume that a write strobe held high for several cycles simply repeats the same write, which is harmless because request latches are level-set. The hold and capture properties read the read-latch state only while the port keeps select and output enable high. They place no rule on how the other port behaves in the meantime. The stimulus drives every input on the falling edge from directed tasks and then from a long stretch of free-running per-cycle choices, so that all of these assumptions hold.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // per-flag state: request latches (1 = request stored) and current owner
    typedef struct packed {
        logic   want_l;
        logic   want_r;
        owner_e owner;
    } flag_st_t;

    // per-port read capture state
    typedef struct packed {
        logic active;
        logic val;
    } rd_st_t;

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic                 ce,
    input  logic                 oe,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_FLAGS-1:0] wr_vec,
    output logic                 wbit,
    output logic [IDX_W-1:0]     idx,
    output logic                 rd_ok,
    output logic                 hold
);
    logic wr_en;
    logic unused_bits;

    // memory enable wins over semaphore select: such a cycle is a no-op
    assign wr_en = sel & ~ce & we;
    assign rd_ok = sel & ~ce & oe & ~we;
    assign hold  = sel & oe;
    assign idx   = addr[IDX_W-1:0];
    assign wbit  = wdata[0];
    assign unused_bits = ^{wdata[DATA_W-1:1], addr[ADDR_W-1:IDX_W]};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_wsel
        assign wr_vec[g] = wr_en && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/sem_flag.sv
module sem_flag
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_l,
    input  logic bit_l,
    input  logic wr_r,
    input  logic bit_r,
    output logic own_l,
    output logic own_r
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_l) st_d.want_l = ~bit_l;
        if (wr_r) st_d.want_r = ~bit_r;
        unique case (st_q.owner)
            OWN_LEFT: begin
                if (!st_d.want_l) st_d.owner = st_d.want_r ? OWN_RIGHT : OWN_NONE;
            end
            OWN_RIGHT: begin
                if (!st_d.want_r) st_d.owner = st_d.want_l ? OWN_LEFT : OWN_NONE;
            end
            default: begin
                if (st_d.want_l)      st_d.owner = OWN_LEFT;
                else if (st_d.want_r) st_d.owner = OWN_RIGHT;
                else                  st_d.owner = OWN_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{want_l: 1'b0, want_r: 1'b0, owner: OWN_NONE};
        else        st_q <= st_d;
    end

    assign own_l = (st_q.owner == OWN_LEFT);
    assign own_r = (st_q.owner == OWN_RIGHT);

    // R4
    free_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_NONE) |-> (!st_q.want_l && !st_q.want_r));

    // R5
    keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_LEFT && !(wr_l && bit_l)) |=> (st_q.owner == OWN_LEFT));

    // R6
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_LEFT && wr_l && bit_l && st_q.want_r && !(wr_r && bit_r))
        |=> (st_q.owner == OWN_RIGHT));

    // R7
    tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_NONE && wr_l && !bit_l && wr_r && !bit_r)
        |=> (st_q.owner == OWN_LEFT && st_q.want_r));

endmodule

// File: rtl/sem_rd_latch.sv
module sem_rd_latch
    import sem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ok,
    input  logic              hold,
    input  logic              flag_bit,
    output logic [DATA_W-1:0] rdata
);
    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            st_d = '0;
        end else if (rd_ok && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.val    = flag_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.active ? {DATA_W{st_q.val}} : '0;

    // R8
    rdata_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0) || (rdata == '1));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && hold && !st_q.active) |=> (rdata == {DATA_W{$past(flag_bit)}}));

    // R9
    held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && st_q.active) |=> $stable(rdata));

endmodule

// File: rtl/sem_flags_dual.sv
module sem_flags_dual #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_ce,
    input  logic              l_oe,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_ce,
    input  logic              r_oe,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NUM_FLAGS);

    logic [NUM_FLAGS-1:0] l_wr_vec, r_wr_vec;
    logic [NUM_FLAGS-1:0] own_l, own_r;
    logic [IDX_W-1:0]     l_idx, r_idx;
    logic                 l_wbit, r_wbit;
    logic                 l_rd_ok, r_rd_ok, l_hold, r_hold;
    logic                 l_flag, r_flag;

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_l (
        .sel(l_sel), .ce(l_ce), .oe(l_oe), .we(l_we), .addr(l_addr), .wdata(l_wdata),
        .wr_vec(l_wr_vec), .wbit(l_wbit), .idx(l_idx), .rd_ok(l_rd_ok), .hold(l_hold)
    );

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_r (
        .sel(r_sel), .ce(r_ce), .oe(r_oe), .we(r_we), .addr(r_addr), .wdata(r_wdata),
        .wr_vec(r_wr_vec), .wbit(r_wbit), .idx(r_idx), .rd_ok(r_rd_ok), .hold(r_hold)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sem_flag i_flag (
            .clk(clk), .rst_n(rst_n),
            .wr_l(l_wr_vec[g]), .bit_l(l_wbit),
            .wr_r(r_wr_vec[g]), .bit_r(r_wbit),
            .own_l(own_l[g]), .own_r(own_r[g])
        );
    end

    // active low: a port sees 0 only for a flag it owns
    assign l_flag = ~own_l[l_idx];
    assign r_flag = ~own_r[r_idx];

    sem_rd_latch #(.DATA_W(DATA_W)) i_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_ok(l_rd_ok), .hold(l_hold),
        .flag_bit(l_flag), .rdata(l_rdata)
    );

    sem_rd_latch #(.DATA_W(DATA_W)) i_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_ok(r_rd_ok), .hold(r_hold),
        .flag_bit(r_flag), .rdata(r_rdata)
    );

    // R4
    exclusive_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    // R1
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l_wr_vec) && $onehot0(r_wr_vec));

    // R10
    illegal_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_ce && !r_sel) |=> ($stable(own_l) && $stable(own_r)));

endmodule

// File: tb/test_sem_flags_dual.sv
`timescale 1ns/1ps
module test_sem_flags_dual;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_ce = 0, l_oe = 0, l_we = 0;
    logic r_sel = 0, r_ce = 0, r_oe = 0, r_we = 0;
    logic [14:0] l_addr = '0, r_addr = '0;
    logic [7:0]  l_wdata = '0, r_wdata = '0;
    logic [7:0]  l_rdata, r_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sem_flags_dual i_sem_flags_dual (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_ce(l_ce), .l_oe(l_oe), .l_we(l_we),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_ce(r_ce), .r_oe(r_oe), .r_we(r_we),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // behavioural reference: holder per flag 0 free, 1 left, 2 right
    int m_owner [8];
    bit m_req_l [8];
    bit m_req_r [8];
    bit m_lact, m_lval, m_ract, m_rval;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_owner[i]) begin m_owner[i] = 0; m_req_l[i] = 0; m_req_r[i] = 0; end
            m_lact = 0; m_lval = 0; m_ract = 0; m_rval = 0;
        end else begin
            int li, ri;
            li = int'(l_addr) % 8;
            ri = int'(r_addr) % 8;
            if (!(l_sel && l_oe)) m_lact = 0;
            else if (!l_ce && !l_we && !m_lact) begin m_lact = 1; m_lval = (m_owner[li] != 1); end
            if (!(r_sel && r_oe)) m_ract = 0;
            else if (!r_ce && !r_we && !m_ract) begin m_ract = 1; m_rval = (m_owner[ri] != 2); end
            if (l_sel && !l_ce && l_we) m_req_l[li] = !l_wdata[0];
            if (r_sel && !r_ce && r_we) m_req_r[ri] = !r_wdata[0];
            for (int f = 0; f < 8; f++) begin
                if (m_owner[f] == 1) begin
                    if (!m_req_l[f]) m_owner[f] = m_req_r[f] ? 2 : 0;
                end else if (m_owner[f] == 2) begin
                    if (!m_req_r[f]) m_owner[f] = m_req_l[f] ? 1 : 0;
                end else begin
                    m_owner[f] = m_req_l[f] ? 1 : (m_req_r[f] ? 2 : 0);
                end
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 model left",  l_rdata, m_lact ? {8{m_lval}} : 8'h00);
            chk("R8 model right", r_rdata, m_ract ? {8{m_rval}} : 8'h00);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(bit side, logic [14:0] a, logic [7:0] d);
        if (!side) begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
        else       begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
        tick();
        if (!side) begin l_sel = 0; l_we = 0; end
        else       begin r_sel = 0; r_we = 0; end
    endtask

    task automatic rd(bit side, logic [14:0] a, logic [7:0] exp, string req);
        if (!side) begin l_sel = 1; l_oe = 1; l_addr = a; end
        else       begin r_sel = 1; r_oe = 1; r_addr = a; end
        tick();
        chk(req, side ? r_rdata : l_rdata, exp);
        if (!side) begin l_sel = 0; l_oe = 0; end
        else       begin r_sel = 0; r_oe = 0; end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tick();
        // R3 / R8: idle read data and reset state
        chk("R8 idle left", l_rdata, 8'h00);
        rd(0, 15'd0, 8'hFF, "R3 left flag0");
        rd(1, 15'd7, 8'hFF, "R3 right flag7");

        // R1 / R4: claim flag 2 with noise in upper address bits
        wr(0, 15'h5AA2, 8'h00);
        rd(0, 15'h0002, 8'h00, "R4 owner reads zero");
        rd(1, 15'h7FF2, 8'hFF, "R1 R4 other side reads ones");
        rd(0, 15'h0006, 8'hFF, "R1 neighbour untouched");

        // R5: right requests owned flag
        wr(1, 15'd2, 8'h00);
        rd(1, 15'd2, 8'hFF, "R5 pending side still ones");
        rd(0, 15'd2, 8'h00, "R5 owner unchanged");

        // R6: hand-over then free
        wr(0, 15'd2, 8'h01);
        rd(1, 15'd2, 8'h00, "R6 handover to right");
        rd(0, 15'd2, 8'hFF, "R6 old owner ones");
        wr(1, 15'd2, 8'h01);
        rd(1, 15'd2, 8'hFF, "R6 free right");
        rd(0, 15'd2, 8'hFF, "R6 free left");

        // R2: only bit 0 matters
        wr(0, 15'd1, 8'hFE);
        rd(0, 15'd1, 8'h00, "R2 FE requests");
        wr(0, 15'd1, 8'h01);
        rd(0, 15'd1, 8'hFF, "R2 01 releases");

        // R7: same-cycle requests
        l_sel = 1; l_we = 1; l_addr = 15'd5; l_wdata = 8'h00;
        r_sel = 1; r_we = 1; r_addr = 15'd5; r_wdata = 8'h00;
        tick();
        l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
        rd(0, 15'd5, 8'h00, "R7 left wins tie");
        rd(1, 15'd5, 8'hFF, "R7 right waits");
        wr(0, 15'd5, 8'h01);
        rd(1, 15'd5, 8'h00, "R7 right pending served");
        wr(1, 15'd5, 8'h01);

        // R9: held read does not follow the flag
        wr(0, 15'd3, 8'h00);
        wr(1, 15'd3, 8'h00);
        r_sel = 1; r_oe = 1; r_addr = 15'd3;
        tick();
        chk("R9 capture", r_rdata, 8'hFF);
        wr(0, 15'd3, 8'h01);
        chk("R9 held after handover", r_rdata, 8'hFF);
        tick();
        chk("R9 still held", r_rdata, 8'hFF);
        r_oe = 0;
        tick();
        chk("R8 cleared after drop", r_rdata, 8'h00);
        r_sel = 0;
        rd(1, 15'd3, 8'h00, "R9 fresh read sees token");
        wr(1, 15'd3, 8'h01);

        // R10: memory enable blocks semaphore access
        l_sel = 1; l_ce = 1; l_we = 1; l_addr = 15'd4; l_wdata = 8'h00;
        tick();
        l_we = 0; l_oe = 1;
        tick();
        chk("R10 no capture with ce", l_rdata, 8'h00);
        l_sel = 0; l_ce = 0; l_oe = 0;
        rd(0, 15'd4, 8'hFF, "R10 no write left");
        rd(1, 15'd4, 8'hFF, "R10 no write right");

        // R11: withdrawn pending request
        wr(0, 15'd6, 8'h00);
        wr(1, 15'd6, 8'h00);
        wr(1, 15'd6, 8'h01);
        wr(0, 15'd6, 8'h01);
        rd(1, 15'd6, 8'hFF, "R11 no handover");
        rd(0, 15'd6, 8'hFF, "R11 flag free");

        // free-running traffic, compared against the model every cycle
        for (int c = 0; c < 4000; c++) begin
            l_sel = $urandom_range(0, 3) != 0;
            l_ce = $urandom_range(0, 9) == 0;
            l_oe = $urandom_range(0, 1) == 1;
            l_we = $urandom_range(0, 2) == 0;
            l_addr = 15'($urandom);
            l_wdata = 8'($urandom);
            r_sel = $urandom_range(0, 3) != 0;
            r_ce = $urandom_range(0, 9) == 0;
            r_oe = $urandom_range(0, 1) == 1;
            r_we = $urandom_range(0, 2) == 0;
            r_addr = 15'($urandom);
            r_wdata = 8'($urandom);
            tick();
        end
        l_sel = 0; l_we = 0; l_oe = 0; l_ce = 0;
        r_sel = 0; r_we = 0; r_oe = 0; r_ce = 0;
        tick();
        chk("R8 idle end left", l_rdata, 8'h00);
        chk("R8 idle end right", r_rdata, 8'h00);

        done = 1;
        summary();
        $finish;
    end

endmodule